// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block watches four active-low modem handshake inputs: clear to send, data set ready, ring indicator and carrier detect. It shows them on an 8-bit status word. The upper nibble gives the current asserted state of each line, with a 1 meaning asserted. The lower nibble holds sticky change flags. Each external line passes through a synchronizer before any edge is detected. The change flags stay set until the status word is read, and a read is marked by a one-cycle strobe.

In loopback mode the external lines are ignored. Four modem control output bits from the control register are routed into the status word in their place. Change detection then follows the looped-back values. A modem status interrupt request is raised while any change flag is set.

Top module: `modem_status_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status[3:0] is 0 and irq is 0.
- R2: With loopback off, status[7] = ~dcd_n, status[6] = ~ri_n, status[5] = ~dsr_n and status[4] = ~cts_n. Each bit shows the input as it stood two clock edges earlier, through a two-flop synchronizer.
- R3: status[0], status[1] and status[3] set one clock edge after the monitored level of clear to send, data set ready or carrier detect changes, in either direction. Change means a difference from the level on the previous cycle.
- R4: status[2] sets only when the ring level goes from asserted to deasserted, that is when ri_n rises. A rise of the ring level does not set it.
- R5: Without a read strobe, a set flag in status[3:0] stays set.
- R6: A flag clears at the clock edge that ends a cycle in which rd_stb is 1. A change detected in that same cycle is kept, so its flag reads 1 afterwards.
- R7: With loop_en = 1, status[4] = mcr_rts, status[5] = mcr_dtr, status[6] = mcr_out1 and status[7] = mcr_out2, with no synchronizer delay.
- R8: With loop_en = 1, the flags in status[3:0] follow changes of the looped-back bits under the rules of R3 and R4. Changes on the external inputs have no effect on them.
- R9: irq is 1 exactly when status[3:0] is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| loop_en | input | 1 | Loopback select from the control register |
| mcr_rts | input | 1 | Request-to-send control bit, looped back into status[4] |
| mcr_dtr | input | 1 | Data-terminal-ready control bit, looped back into status[5] |
| mcr_out1 | input | 1 | General output 1 control bit, looped back into status[6] |
| mcr_out2 | input | 1 | General output 2 control bit, looped back into status[7] |
| rd_stb | input | 1 | One-cycle strobe marking a read of the status word |
| status | output | 8 | Line levels in bits 7:4, sticky change flags in bits 3:0 |
| irq | output | 1 | Modem status interrupt request |

## Verification
A stuck or missed change flag shows at the ports one edge after the level changes, in status[3:0] and in irq together. A stale synchronizer stage shows in the upper nibble two edges after an input toggles. A flag that clears too early or too late shows in the cycle right after a read strobe. A same-cycle change that is dropped shows as a 0 where a 1 is expected in that same cycle. In loopback, a wrong routing is visible at once in the upper nibble. A leak from the external lines shows one edge later as a spurious flag.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NLINES = 4;
  localparam int RING_IDX = 2;
  typedef logic [NLINES-1:0] line_vec_t;

  // Change events: any toggle, except the ring line, which reports only a fall of its asserted level.
  function automatic line_vec_t msr_events(line_vec_t cur, line_vec_t prv);
    line_vec_t ev;
    ev = cur ^ prv;
    ev[RING_IDX] = prv[RING_IDX] & ~cur[RING_IDX];
    return ev;
  endfunction

  function automatic logic [2*NLINES-1:0] msr_pack(line_vec_t lvl, line_vec_t flg);
    return {lvl, flg};
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lvl,
  input  logic      rd_clr,
  output line_vec_t flags,
  output line_vec_t evt
);
  line_vec_t prev_lvl;

  assign evt = msr_events(lvl, prev_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      flags    <= '0;
    end else begin
      prev_lvl <= lvl;
      flags    <= (rd_clr ? '0 : flags) | evt;
    end
  end

  // R5: without a read, no set flag drops
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags)));
  // R6: after a read, only flags of same-cycle events survive
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((flags & ~$past(evt)) == '0));
  // R3: every detected event is latched
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       mcr_rts,
  input  logic       mcr_dtr,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic       irq
);
  line_vec_t raw_n, sync_n, ext_lvl, loop_lvl, cur_lvl, flags, evt;
  logic      ring_fall;

  assign raw_n = {dcd_n, ri_n, dsr_n, cts_n};

  msr_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n)
  );

  assign ext_lvl  = ~sync_n;
  assign loop_lvl = {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};
  assign cur_lvl  = loop_en ? loop_lvl : ext_lvl;

  msr_delta u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(cur_lvl), .rd_clr(rd_stb),
    .flags(flags), .evt(evt)
  );

  assign ring_fall = evt[RING_IDX];
  assign status    = msr_pack(cur_lvl, flags);
  assign irq       = |flags;

  // R4: the ring flag only rises after a trailing ring edge
  a_r4_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(ring_fall));
  // R7: loopback bits are routed straight to the upper nibble
  a_r7_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (status[7:4] == {mcr_out2, mcr_out1, mcr_dtr, mcr_rts}));
  // R9: interrupt request tracks the flag nibble
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status[3:0] != 4'h0));
endmodule

// File: tb/modem_status_reg_test.sv
module modem_status_reg_test;
  logic clk = 0, rst_n = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic loop_en = 0, rts = 0, dtr = 0, out1 = 0, out2 = 0, rd = 0;
  logic [7:0] status;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  modem_status_reg uut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .loop_en(loop_en), .mcr_rts(rts), .mcr_dtr(dtr),
    .mcr_out1(out1), .mcr_out2(out2), .rd_stb(rd), .status(status), .irq(irq)
  );

  // Bench model, written from the requirements
  logic [3:0] ms1, ms2, mprev, mflag;
  function automatic logic [3:0] exp_lvl(logic lp, logic [3:0] s2n);
    return lp ? {out2, out1, dtr, rts} : ~s2n;
  endfunction
  function automatic logic [3:0] exp_ev(logic [3:0] c, logic [3:0] p);
    logic [3:0] e;
    e[0] = c[0] != p[0];
    e[1] = c[1] != p[1];
    e[3] = c[3] != p[3];
    e[2] = p[2] && !c[2];
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 <= 4'hF; ms2 <= 4'hF; mprev <= 4'h0; mflag <= 4'h0;
    end else begin
      ms1   <= {dcd_n, ri_n, dsr_n, cts_n};
      ms2   <= ms1;
      mprev <= exp_lvl(loop_en, ms2);
      mflag <= (rd ? 4'h0 : mflag) | exp_ev(exp_lvl(loop_en, ms2), mprev);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] el;
    el = exp_lvl(loop_en, ms2);
    chk(loop_en ? "R7 level" : "R2 level", {4'h0, status[7:4]}, {4'h0, el});
    chk(loop_en ? "R8 R3 R5 R6 flags" : "R3 R5 R6 flags",
        {5'h0, status[3], status[1:0]}, {5'h0, mflag[3], mflag[1:0]});
    chk("R4 ring flag", {7'h0, status[2]}, {7'h0, mflag[2]});
    chk("R9 irq", {7'h0, irq}, {7'h0, |mflag});
  endtask

  task automatic drive_rand(int pin, int prd, logic lp);
    loop_en = lp;
    if ($urandom_range(pin - 1) == 0) cts_n = ~cts_n;
    if ($urandom_range(pin - 1) == 0) dsr_n = ~dsr_n;
    if ($urandom_range(pin - 1) == 0) ri_n  = ~ri_n;
    if ($urandom_range(pin - 1) == 0) dcd_n = ~dcd_n;
    if ($urandom_range(pin - 1) == 0) rts  = ~rts;
    if ($urandom_range(pin - 1) == 0) dtr  = ~dtr;
    if ($urandom_range(pin - 1) == 0) out1 = ~out1;
    if ($urandom_range(pin - 1) == 0) out2 = ~out2;
    rd = ($urandom_range(prd - 1) == 0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R1 reset flags", {4'h0, status[3:0]}, 8'h00);
    chk("R1 reset irq", {7'h0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {4'h0, status[3:0]}, 8'h00);

    // Directed R4: ri_n falling (ring asserted) must not set bit 2, rising must
    ri_n = 0;
    repeat (4) begin @(negedge clk); compare(); end
    chk("R4 no flag on leading edge", {7'h0, status[2]}, 8'h00);
    ri_n = 1;
    repeat (4) begin @(negedge clk); compare(); end
    chk("R4 flag on trailing edge", {7'h0, status[2]}, 8'h01);
    rd = 1; @(negedge clk); rd = 0; compare();

    // Directed R6: change and read in the same cycle, in loopback
    loop_en = 1; @(negedge clk); compare();
    rd = 1; @(negedge clk); rd = 0; compare();
    rts = 1; rd = 1;
    @(negedge clk); rd = 0;
    chk("R6 same-cycle event kept", {7'h0, status[0]}, 8'h01);
    compare();
    // Directed R8: external toggles ignored in loopback
    cts_n = 0; dcd_n = 0;
    rd = 1; @(negedge clk); rd = 0;
    repeat (4) begin @(negedge clk); compare(); end
    chk("R8 external ignored", {4'h0, status[3:0]}, 8'h00);
    cts_n = 1; dcd_n = 1; loop_en = 0;
    repeat (4) begin @(negedge clk); compare(); end

    for (int i = 0; i < 3000; i++) begin drive_rand(6, 4, 1'b0); @(negedge clk); compare(); end
    for (int i = 0; i < 3000; i++) begin drive_rand(6, 4, 1'b1); @(negedge clk); compare(); end
    for (int i = 0; i < 3000; i++) begin
      drive_rand(5, 3, ($urandom_range(15) == 0) ? ~loop_en : loop_en);
      @(negedge clk); compare();
    end
    // R5: long hold without reads
    rd = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); compare(); end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule